// File: doc/BRIEF.md
# In-Order Issue Register Scoreboard

This block tracks register hazards for a small dual-issue core that both issues and completes instructions in program order. Eight architectural registers are covered. For each register it keeps two counters: how many in-flight instructions read that register, and how many write it. Each cycle the front end offers up to two decoded instructions, oldest in slot 0. Every instruction names two source registers, one destination register and whether it is a multiply. The block answers in the same cycle with a grant per slot. A slot is granted only when it causes no read-after-write, write-after-read or write-after-write conflict.

Granted instructions enter a small completion queue in program order. Each entry holds the instruction's registers and a timer loaded with the instruction's fixed execution latency. An entry retires only from the head of the queue, and only once its timer has run out. At most two entries retire per cycle. Retirement gives back exactly the counts the instruction took when it issued. These decrements are applied before that cycle's hazard check, so a register freed in a cycle can be claimed by an instruction offered in the same cycle.

The counters are registered and exposed for the core's visibility. The grants are combinational from the offer and the current state, so the front end can advance its decode slots within the cycle.

Top module: `issue_scoreboard`

## Requirements
- R1: A synchronous active-high `rst` clears every read and write count and empties the completion queue. In the cycle after release, all counts read 0 and a valid offer is granted.
- R2: On issue, each source operand adds one to its register's read count, so a register named in both source fields adds two. The destination adds one to its register's write count. Register i occupies bits [i*CNT_W +: CNT_W] of `rd_count` and `wr_count`. The values shown after a clock edge include every instruction issued in the cycle before that edge.
- R3: An offer is refused while either of its source registers has a nonzero write count (read-after-write).
- R4: An offer is refused while its destination has a nonzero read count (write-after-read) or a nonzero write count (write-after-write). The instruction's own sources do not count against its own destination.
- R5: Slot 1 is granted only in a cycle where slot 0 is granted. Slot 1 is also refused when a source of slot 1 equals the destination of slot 0, or when the destination of slot 1 equals a source or the destination of slot 0.
- R6: Retirement subtracts exactly the counts its instruction added at issue. These decrements are applied before the same cycle's hazard check.
- R7: With `inN_mul` = 1 an instruction has a latency of 3 cycles; otherwise its latency is 1 cycle. An instruction issued in cycle c, with nothing older pending, releases its registers in cycle c+latency+1.
- R8: Retirement is in program order. A younger instruction stays counted until every older instruction has retired, even when its own latency has already run out.
- R9: The completion queue holds DEPTH instructions. A slot is granted only if the queue will have room for it after that cycle's retirements. Up to two instructions retire in one cycle.
- R10: Read counts accumulate across in-flight instructions and can exceed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Slot 0 (older) offer valid |
| in0_src_a | input | 3 | Slot 0 first source register |
| in0_src_b | input | 3 | Slot 0 second source register |
| in0_dst | input | 3 | Slot 0 destination register |
| in0_mul | input | 1 | Slot 0 is a multiply (1) or a single-cycle op (0) |
| in1_valid | input | 1 | Slot 1 (younger) offer valid |
| in1_src_a | input | 3 | Slot 1 first source register |
| in1_src_b | input | 3 | Slot 1 second source register |
| in1_dst | input | 3 | Slot 1 destination register |
| in1_mul | input | 1 | Slot 1 is a multiply (1) or a single-cycle op (0) |
| grant0 | output | 1 | Slot 0 issues this cycle |
| grant1 | output | 1 | Slot 1 issues this cycle |
| rd_count | output | 8*CNT_W (32) | Registered read counts, one field per register |
| wr_count | output | 8*CNT_W (32) | Registered write counts, one field per register |

## Verification
The bench builds the block with DEPTH = 4, a multiply latency of 3 and a single-cycle latency of 1, which gives 4-bit count fields. A depth of four lets two cycles of paired multiplies fill the queue, so the full-queue stall and a two-entry retirement in a single cycle can both be reached. A multiply held at the head lets the in-order retirement hold-back be seen on a younger add whose own latency has already run out. Hand-computed scenarios of a few cycles each are followed by a long pseudo-random run that includes a reset taken while instructions are in flight.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef logic [IDX_W-1:0] ridx_t;

  // registers named by one instruction
  typedef struct packed {
    ridx_t src_a;
    ridx_t src_b;
    ridx_t dst;
  } regs_t;

  // a decoded offer: registers plus operation class
  typedef struct packed {
    regs_t regs;
    logic  is_mul;
  } op_t;
endpackage

// File: rtl/sb_count_bank.sv
`timescale 1ns/1ps
module sb_count_bank
  import sb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [1:0]                         iss_en,
  input  regs_t [1:0]                        iss_regs,
  input  logic [1:0]                         ret_en,
  input  regs_t [1:0]                        ret_regs,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     rd_q,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     wr_q,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     rd_eff,
  output logic [NUM_REGS-1:0][CNT_W-1:0]     wr_eff
);
  logic [NUM_REGS-1:0][CNT_W-1:0] rd_dec, wr_dec, rd_inc, wr_inc;
  logic [NUM_REGS-1:0][CNT_W-1:0] rd_nxt, wr_nxt;

  // retirement first, then this cycle's issues on top
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      rd_dec[r] = '0;
      wr_dec[r] = '0;
      rd_inc[r] = '0;
      wr_inc[r] = '0;
      for (int k = 0; k < 2; k++) begin
        if (ret_en[k]) begin
          rd_dec[r] = rd_dec[r] + CNT_W'(ret_regs[k].src_a == ridx_t'(r))
                                + CNT_W'(ret_regs[k].src_b == ridx_t'(r));
          wr_dec[r] = wr_dec[r] + CNT_W'(ret_regs[k].dst == ridx_t'(r));
        end
        if (iss_en[k]) begin
          rd_inc[r] = rd_inc[r] + CNT_W'(iss_regs[k].src_a == ridx_t'(r))
                                + CNT_W'(iss_regs[k].src_b == ridx_t'(r));
          wr_inc[r] = wr_inc[r] + CNT_W'(iss_regs[k].dst == ridx_t'(r));
        end
      end
      rd_eff[r] = rd_q[r] - rd_dec[r];
      wr_eff[r] = wr_q[r] - wr_dec[r];
      rd_nxt[r] = rd_eff[r] + rd_inc[r];
      wr_nxt[r] = wr_eff[r] + wr_inc[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_nxt;
      wr_q <= wr_nxt;
    end
  end

  // R6: a retirement never takes back more than is held
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_guard
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (rd_dec[g] <= rd_q[g]) && (wr_dec[g] <= wr_q[g]));
  end
endmodule

// File: rtl/sb_hazard.sv
`timescale 1ns/1ps
module sb_hazard
  import sb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [1:0]                     offer_v,
  input  regs_t [1:0]                    offer,
  input  logic [NUM_REGS-1:0][CNT_W-1:0] rd_eff,
  input  logic [NUM_REGS-1:0][CNT_W-1:0] wr_eff,
  input  logic [1:0]                     room,
  output logic [1:0]                     grant
);
  logic [1:0] blocked;
  logic       pair_clash;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      blocked[k] = (wr_eff[offer[k].src_a] != '0) ||
                   (wr_eff[offer[k].src_b] != '0) ||
                   (rd_eff[offer[k].dst]   != '0) ||
                   (wr_eff[offer[k].dst]   != '0);
    end
    // younger slot against the older one issuing beside it
    pair_clash = (offer[1].src_a == offer[0].dst)   ||
                 (offer[1].src_b == offer[0].dst)   ||
                 (offer[1].dst   == offer[0].src_a) ||
                 (offer[1].dst   == offer[0].src_b) ||
                 (offer[1].dst   == offer[0].dst);
    grant[0] = offer_v[0] && !blocked[0] && (room != 2'd0);
    grant[1] = grant[0] && offer_v[1] && !blocked[1] && !pair_clash &&
               (room == 2'd2);
  end
endmodule

// File: rtl/sb_retire_queue.sv
`timescale 1ns/1ps
module sb_retire_queue
  import sb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MUL_LAT = 3,
  parameter int ALU_LAT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  push_en,
  input  op_t [1:0]   push_op,
  output logic [1:0]  ret_en,
  output regs_t [1:0] ret_regs,
  output logic [1:0]  room
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int MAXL  = (MUL_LAT > ALU_LAT) ? MUL_LAT : ALU_LAT;
  localparam int LAT_W = $clog2(MAXL + 1);

  regs_t             slot_regs [DEPTH];
  logic [LAT_W-1:0]  slot_tmr  [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt1, wr_nxt1, wr_adv, rd_adv;
  logic [OCC_W-1:0]  occ, n_pop, n_push, free_after;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [LAT_W-1:0] lat_of(input logic mul);
    return mul ? LAT_W'(MUL_LAT) : LAT_W'(ALU_LAT);
  endfunction

  always_comb begin
    rd_nxt1     = ptr_inc(rd_ptr);
    wr_nxt1     = ptr_inc(wr_ptr);
    ret_en[0]   = (occ != '0) && (slot_tmr[rd_ptr] == '0);
    ret_en[1]   = ret_en[0] && (occ >= OCC_W'(2)) && (slot_tmr[rd_nxt1] == '0);
    ret_regs[0] = slot_regs[rd_ptr];
    ret_regs[1] = slot_regs[rd_nxt1];
    n_pop       = OCC_W'(ret_en[0]) + OCC_W'(ret_en[1]);
    n_push      = OCC_W'(push_en[0]) + OCC_W'(push_en[1]);
    free_after  = OCC_W'(DEPTH) - (occ - n_pop);
    room        = (free_after >= OCC_W'(2)) ? 2'd2 : 2'(free_after);
    rd_adv      = ret_en[1] ? ptr_inc(rd_nxt1) : (ret_en[0] ? rd_nxt1 : rd_ptr);
    wr_adv      = push_en[1] ? ptr_inc(wr_nxt1) : (push_en[0] ? wr_nxt1 : wr_ptr);
  end

  // register payload: plain write ports, no reset
  always_ff @(posedge clk) begin
    if (push_en[0]) slot_regs[wr_ptr]  <= push_op[0].regs;
    if (push_en[1]) slot_regs[wr_nxt1] <= push_op[1].regs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
      for (int i = 0; i < DEPTH; i++) slot_tmr[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_tmr[i] != '0) slot_tmr[i] <= slot_tmr[i] - LAT_W'(1);
      if (push_en[0]) slot_tmr[wr_ptr]  <= lat_of(push_op[0].is_mul);
      if (push_en[1]) slot_tmr[wr_nxt1] <= lat_of(push_op[1].is_mul);
      rd_ptr <= rd_adv;
      wr_ptr <= wr_adv;
      occ    <= occ - n_pop + n_push;
    end
  end

  a_r9_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  a_r9_occ_track: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> occ == $past(occ) - $past(n_pop) + $past(n_push));
endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MUL_LAT = 3,
  parameter int ALU_LAT = 1,
  localparam int CNT_W  = $clog2(2 * DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in0_valid,
  input  logic [IDX_W-1:0]          in0_src_a,
  input  logic [IDX_W-1:0]          in0_src_b,
  input  logic [IDX_W-1:0]          in0_dst,
  input  logic                      in0_mul,
  input  logic                      in1_valid,
  input  logic [IDX_W-1:0]          in1_src_a,
  input  logic [IDX_W-1:0]          in1_src_b,
  input  logic [IDX_W-1:0]          in1_dst,
  input  logic                      in1_mul,
  output logic                      grant0,
  output logic                      grant1,
  output logic [NUM_REGS*CNT_W-1:0] rd_count,
  output logic [NUM_REGS*CNT_W-1:0] wr_count
);
  localparam int TW = CNT_W + IDX_W;

  op_t [1:0]                      offer;
  regs_t [1:0]                    offer_regs, ret_regs;
  logic [1:0]                     grant, ret_en, room;
  logic [NUM_REGS-1:0][CNT_W-1:0] rd_q, wr_q, rd_eff, wr_eff;
  logic [TW-1:0]                  wr_total;

  assign offer[0]      = {in0_src_a, in0_src_b, in0_dst, in0_mul};
  assign offer[1]      = {in1_src_a, in1_src_b, in1_dst, in1_mul};
  assign offer_regs[0] = offer[0].regs;
  assign offer_regs[1] = offer[1].regs;

  sb_count_bank #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst,
    .iss_en(grant), .iss_regs(offer_regs),
    .ret_en, .ret_regs,
    .rd_q, .wr_q, .rd_eff, .wr_eff
  );

  sb_hazard #(.CNT_W(CNT_W)) u_haz (
    .offer_v({in1_valid, in0_valid}), .offer(offer_regs),
    .rd_eff, .wr_eff, .room, .grant
  );

  sb_retire_queue #(.DEPTH(DEPTH), .MUL_LAT(MUL_LAT), .ALU_LAT(ALU_LAT)) u_rq (
    .clk, .rst,
    .push_en(grant), .push_op(offer),
    .ret_en, .ret_regs, .room
  );

  assign grant0   = grant[0];
  assign grant1   = grant[1];
  assign rd_count = rd_q;
  assign wr_count = wr_q;

  always_comb begin
    wr_total = '0;
    for (int r = 0; r < NUM_REGS; r++) wr_total = wr_total + TW'(wr_q[r]);
  end

  // R3: a granted slot 0 never reads a register still being written
  a_r3_raw_guard: assert property (@(posedge clk) disable iff (rst)
    grant0 |-> (wr_eff[in0_src_a] == '0) && (wr_eff[in0_src_b] == '0));

  // R4: a granted slot 0 finds its destination idle
  a_r4_dst_guard: assert property (@(posedge clk) disable iff (rst)
    grant0 |-> (rd_eff[in0_dst] == '0) && (wr_eff[in0_dst] == '0));

  // R2: a lone issue with no retirement adds exactly one pending write
  a_r2_write_track: assert property (@(posedge clk) disable iff (rst)
    (grant == 2'b01 && ret_en == 2'b00) |=> wr_total == $past(wr_total) + TW'(1));
endmodule

// File: tb/sim_issue_scoreboard.sv
`timescale 1ns/1ps
module sim_issue_scoreboard;
  localparam int DEPTH = 4;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v0 = 0, v1 = 0, m0 = 0, m1 = 0;
  logic [2:0] a0 = 0, b0 = 0, d0 = 0, a1 = 0, b1 = 0, d1 = 0;
  logic grant0, grant1;
  logic [31:0] rd_count, wr_count;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state built from the requirements
  int m_rd[8], m_wr[8];
  int qa[$], qb[$], qd[$], qt[$];
  logic [31:0] exp_rd[$], exp_wr[$];
  string exp_tag[$];
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  issue_scoreboard #(.DEPTH(DEPTH), .MUL_LAT(3), .ALU_LAT(1)) u0 (
    .clk, .rst,
    .in0_valid(v0), .in0_src_a(a0), .in0_src_b(b0), .in0_dst(d0), .in0_mul(m0),
    .in1_valid(v1), .in1_src_a(a1), .in1_src_b(b1), .in1_dst(d1), .in1_mul(m1),
    .grant0, .grant1, .rd_count, .wr_count
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_hz(input int a, input int b, input int d);
    return m_wr[a] != 0 || m_wr[b] != 0 || m_rd[d] != 0 || m_wr[d] != 0;
  endfunction

  function automatic logic [31:0] pack_rd();
    logic [31:0] v;
    for (int r = 0; r < 8; r++) v[r*CW +: CW] = 4'(m_rd[r]);
    return v;
  endfunction

  function automatic logic [31:0] pack_wr();
    logic [31:0] v;
    for (int r = 0; r < 8; r++) v[r*CW +: CW] = 4'(m_wr[r]);
    return v;
  endfunction

  task automatic m_pop();
    m_rd[qa[0]]--; m_rd[qb[0]]--; m_wr[qd[0]]--;
    void'(qa.pop_front()); void'(qb.pop_front());
    void'(qd.pop_front()); void'(qt.pop_front());
  endtask

  task automatic m_push(input int a, input int b, input int d, input bit mul);
    qa.push_back(a); qb.push_back(b); qd.push_back(d); qt.push_back(mul ? 3 : 1);
    m_rd[a]++; m_rd[b]++; m_wr[d]++;
  endtask

  // driver: one clock cycle of offers; h0/h1 are hand values, -1 = none
  task automatic step(input bit iv0, input int ia0, input int ib0, input int id0, input bit im0,
                      input bit iv1, input int ia1, input int ib1, input int id1, input bit im1,
                      input int h0, input int h1, input string req);
    int room;
    bit e0, e1;
    @(negedge clk);
    v0 = iv0; a0 = 3'(ia0); b0 = 3'(ib0); d0 = 3'(id0); m0 = im0;
    v1 = iv1; a1 = 3'(ia1); b1 = 3'(ib1); d1 = 3'(id1); m1 = im1;
    #1;
    // R6/R8/R9: in-order retirement of up to two expired heads first
    if (qt.size() > 0 && qt[0] == 0) begin
      m_pop();
      if (qt.size() > 0 && qt[0] == 0) m_pop();
    end
    room = DEPTH - qt.size();
    if (room > 2) room = 2;
    e0 = iv0 && !m_hz(ia0, ib0, id0) && room >= 1;
    e1 = e0 && iv1 && !m_hz(ia1, ib1, id1) && room >= 2 &&
         !(ia1 == id0 || ib1 == id0 || id1 == ia0 || id1 == ib0 || id1 == id0);
    chk(grant0 == e0, req, "grant0 vs model", grant0, e0);
    chk(grant1 == e1, req, "grant1 vs model", grant1, e1);
    if (h0 >= 0) chk(grant0 == h0[0], req, "grant0 hand", grant0, h0);
    if (h1 >= 0) chk(grant1 == h1[0], req, "grant1 hand", grant1, h1);
    foreach (qt[i]) if (qt[i] > 0) qt[i]--;
    if (e0) m_push(ia0, ib0, id0, im0);
    if (e1) m_push(ia1, ib1, id1, im1);
    exp_rd.push_back(pack_rd());
    exp_wr.push_back(pack_wr());
    exp_tag.push_back(req);
  endtask

  // monitor: compare registered counts one cycle after each drive
  always @(negedge clk) begin
    if (!rst && exp_rd.size() > 0) begin
      chk(rd_count == exp_rd[0], exp_tag[0], "rd_count (R2/R6)", rd_count, exp_rd[0]);
      chk(wr_count == exp_wr[0], exp_tag[0], "wr_count (R2/R6)", wr_count, exp_wr[0]);
      void'(exp_rd.pop_front()); void'(exp_wr.pop_front()); void'(exp_tag.pop_front());
    end
  end

  // hand check of one read field and one write field after the last step's edge
  task automatic peek(input int ri, input int erd, input int wi, input int ewr, input string req);
    @(posedge clk);
    #1;
    chk(rd_count[ri*CW +: CW] == 4'(erd), req, $sformatf("rd R%0d", ri), rd_count[ri*CW +: CW], erd);
    chk(wr_count[wi*CW +: CW] == 4'(ewr), req, $sformatf("wr R%0d", wi), wr_count[wi*CW +: CW], ewr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst = 1'b1; v0 = 0; v1 = 0;
    for (int r = 0; r < 8; r++) begin m_rd[r] = 0; m_wr[r] = 0; end
    qa.delete(); qb.delete(); qd.delete(); qt.delete();
    exp_rd.delete(); exp_wr.delete(); exp_tag.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    rst = 1'b0;
    chk(rd_count == 0, "R1", "rd_count after reset", rd_count, 0);
    chk(wr_count == 0, "R1", "wr_count after reset", wr_count, 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 R2: empty board grants both; mul R3=R0*R1, add R4=R0+R2
    step(1,0,1,3,1, 1,0,2,4,0, 1,1,"R1");
    // R3: R6=R1+R4 reads R4 still being written
    step(1,0,1,5,0, 1,1,4,6,0, 1,0,"R3");
    peek(0,3, 4,1, "R10");
    // R8: add R4 expired but waits behind the multiply
    step(1,1,4,6,0, 1,1,2,7,1, 0,0,"R8");
    step(1,1,4,6,0, 1,1,2,7,1, 0,0,"R8");
    peek(0,3, 4,1, "R8");
    // R6: multiply and add retire, R4 reusable the same cycle
    step(1,1,4,6,0, 1,1,2,7,1, 1,1,"R6");
    peek(0,1, 4,0, "R6");

    // R7: multiply latency
    do_reset();
    step(1,0,1,3,1, 0,0,0,0,0, 1,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 0,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 0,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 0,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 1,0,"R7");
    // R7: single-cycle latency
    do_reset();
    step(1,0,1,3,0, 0,0,0,0,0, 1,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 0,0,"R7");
    step(1,3,1,5,0, 0,0,0,0,0, 1,0,"R7");

    // R9: fill the queue with four multiplies
    do_reset();
    step(1,1,1,2,1, 1,1,1,3,1, 1,1,"R2");
    step(1,1,1,4,1, 1,1,1,5,1, 1,1,"R2");
    peek(1,8, 2,1, "R2");
    step(1,1,1,6,1, 0,0,0,0,0, 0,0,"R9");
    step(1,1,1,6,1, 0,0,0,0,0, 0,0,"R9");
    step(1,1,1,6,1, 0,0,0,0,0, 1,0,"R9");
    peek(1,6, 2,0, "R9");

    // R4: write-after-read, and the younger slot blocked behind it
    do_reset();
    step(1,0,1,3,0, 0,0,0,0,0, 1,0,"R4");
    step(1,2,2,0,0, 1,2,2,6,0, 0,0,"R4");
    // R5: pair conflicts
    do_reset();
    step(1,1,2,4,0, 1,4,1,5,0, 1,0,"R5");
    do_reset();
    step(1,1,2,4,0, 1,6,6,1,0, 1,0,"R5");
    do_reset();
    step(1,1,2,4,0, 1,6,6,4,0, 1,0,"R5");
    do_reset();
    step(0,0,0,0,0, 1,6,6,5,0, 0,0,"R5");
    // R4: write-after-write
    step(1,1,2,4,0, 0,0,0,0,0, 1,0,"R4");
    step(1,5,5,4,0, 0,0,0,0,0, 0,0,"R4");
    // R4: own source equal to own destination is allowed
    do_reset();
    step(1,3,1,3,1, 0,0,0,0,0, 1,0,"R4");

    // pseudo-random run with a reset taken in flight
    for (int n = 0; n < 600; n++) begin
      logic [15:0] x, y;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      x = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      y = lf;
      step(x[10] | x[11], int'(x[2:0]), int'(x[5:3]), int'(x[8:6]), x[9],
           y[10] | y[11], int'(y[2:0]), int'(y[5:3]), int'(y[8:6]), y[9],
           -1, -1, "R3 R4 R5 R6 R7 R8 R9 random");
      if (n == 300) begin
        do_reset();
        // R1: reset emptied the board, any offer is free
        step(1,0,1,2,1, 0,0,0,0,0, 1,0,"R1");
      end
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule